// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block holds the configuration-address word of a PCI host bridge. In the main-bus (translating) variant, the host selects a target device by writing a one-hot select bit somewhere in data bits 11 to 31. The block priority-encodes that bit into a five-bit device number. It stores a packed word made of an enable flag, a bus number, the device, and the function/register fields. A host read rebuilds the one-hot view from the stored word. Secondary bridges use a pass-through variant instead, which stores the written value almost unchanged. A static parameter can add a byte swap on both the write path and the read path for a big-endian host.

The stored word leaves on `cfg_word` for a downstream data-port block. The host writes with a single-cycle strobe. Reads are combinational from the stored word, and access size plays no part.

The block also routes interrupts. Device slot `j` reports its four INTx levels on `dev_intx[4j+3:4j]`, with pin 0 being INTA. Each level is rotated onto one of four bridge lines by slot number. Those four lines then drive a window of a wider interrupt-controller bank through a register.

Top module: `cfg_addr_xlate`

## Requirements
- R1: Reset clears the stored word and `cfg_word` to 0 and all of `irq_out` to 0. After reset, a translating read returns 0x00000001 (0x01000000 with the byte swap), and a pass-through read returns 0x00000001.
- R2: A translating write places the index (11..31) of the lowest set bit among data bits 11..31 into stored bits 15:11. Any higher set bits are ignored. The result is visible on `cfg_word` on the cycle after the strobe.
- R3: A translating write with none of data bits 11..31 set stores device number 0.
- R4: A translating write always sets stored bit 31 and keeps data bits 10:2 in stored bits 10:2. Stored bits 1:0 and 30:24 are 0.
- R5: In translating mode, data bit 0 picks the bus field at stored bits 23:16. A 1 gives bus 1 and a 0 gives bus 0.
- R6: A translating read returns a one-hot bit at position stored[15:11], ORed with stored[10:8] at bits 10:8 and stored[7:2] at bits 7:2. All other bits read 0.
- R7: A pass-through write stores the data with bit 0 cleared and bit 31 set. A pass-through read returns the stored word with bit 0 set and bit 31 cleared.
- R8: With the byte-swap option enabled, write data is byte-reversed before decoding and read data is byte-reversed after forming. `cfg_word` itself is not swapped.
- R9: While `wr_en` is low, changes on `wr_data` leave the stored word unchanged.
- R10: Pin n of device slot j drives bridge line (n + j) mod 4. Bridge line k appears as a level on `irq_out[8+k]` one cycle later. Several sources on one line OR together.
- R11: `irq_out` bits outside 8..11 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe for the address register |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Host read data (combinational) |
| cfg_word | output | 32 | Packed configuration word for the data port |
| dev_intx | input | 4*N_DEV | INTx levels, slot j at bits 4j+3:4j |
| irq_out | output | IRQ_W | Interrupt-controller bank lines |

## Verification
Three instances receive the same stimulus: a translating one, a byte-swapping translating one, and a pass-through one. The write sweep walks the select bit across every position from 11 to 31. Each position is tried with both bus forms and with alternating function/register patterns. Some writes also carry extra higher bits, which separates a lowest-bit encoder from a highest-bit one. A write with no select bit covers the empty case. A held write with changed data shows that the strobe gates updates. The interrupt sweep drives each slot/pin alone, which exposes any error in the rotation. Combined sources show that lines OR together.

// File: rtl/cax_pkg.sv
package cax_pkg;
  localparam int WORD_W = 32;
  localparam int SEL_LO = 11;
  localparam int EN_BIT = 31;
  localparam logic [WORD_W-1:0] FNREG_MASK = 32'h0000_07FC;
  localparam logic [WORD_W-1:0] REGLO_MASK = 32'h0000_00FC;

  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/cax_wr_encode.sv
module cax_wr_encode
  import cax_pkg::*;
#(
  parameter bit XLATE = 1'b1
) (
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] nxt
);
  generate
    if (XLATE) begin : g_xlate
      logic [4:0] dev;
      always_comb begin
        dev = 5'd0;
        for (int i = WORD_W - 1; i >= SEL_LO; i--) begin
          if (din[i]) dev = 5'(i);
        end
        nxt = '0;
        nxt[EN_BIT] = 1'b1;
        nxt[23:16] = {7'd0, din[0]};
        nxt[15:11] = dev;
        nxt = nxt | (din & FNREG_MASK);
      end
    end else begin : g_pass
      always_comb begin
        nxt = din;
        nxt[0] = 1'b0;
        nxt[EN_BIT] = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/cax_addr_reg.sv
module cax_addr_reg
  import cax_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] nxt,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (wr_en) q <= nxt;
  end

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q));
  // R4
  enable_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> q[EN_BIT]);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> q == '0);
endmodule

// File: rtl/cax_rd_decode.sv
module cax_rd_decode
  import cax_pkg::*;
#(
  parameter bit XLATE = 1'b1
) (
  input  logic [WORD_W-1:0] q,
  output logic [WORD_W-1:0] val
);
  generate
    if (XLATE) begin : g_xlate
      always_comb begin
        val = (WORD_W'(1) << q[15:11]) | (q & REGLO_MASK);
        val[10:8] = val[10:8] | q[10:8];
      end
    end else begin : g_pass
      always_comb begin
        val = q;
        val[0] = 1'b1;
        val[EN_BIT] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/cax_irq_swizzle.sv
module cax_irq_swizzle #(
  parameter int N_DEV    = 16,
  parameter int IRQ_W    = 16,
  parameter int IRQ_BASE = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [4*N_DEV-1:0] intx,
  output logic [IRQ_W-1:0]   irq_out
);
  localparam int N_LINES = 4;
  logic [N_LINES-1:0] lines;
  logic [IRQ_W-1:0]   bank;

  always_comb begin
    lines = '0;
    for (int j = 0; j < N_DEV; j++) begin
      for (int n = 0; n < N_LINES; n++) begin
        lines[2'((n + j) % N_LINES)] = lines[2'((n + j) % N_LINES)] | intx[N_LINES*j + n];
      end
    end
    bank = '0;
    bank[IRQ_BASE +: N_LINES] = lines;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else irq_out <= bank;
  end

  // R10
  quiet_inputs_chk: assert property (@(posedge clk) disable iff (rst)
    (intx == '0) |=> (irq_out == '0));
  // R11
  outside_window_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_out) == $countones(irq_out[IRQ_BASE +: N_LINES]));
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
  import cax_pkg::*;
#(
  parameter bit XLATE      = 1'b1,
  parameter bit BIG_ENDIAN = 1'b0,
  parameter int N_DEV      = 16,
  parameter int IRQ_W      = 16,
  parameter int IRQ_BASE   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  output logic [31:0]        cfg_word,
  input  logic [4*N_DEV-1:0] dev_intx,
  output logic [IRQ_W-1:0]   irq_out
);
  logic [WORD_W-1:0] din, nxt, q, rval;

  generate
    if (BIG_ENDIAN) begin : g_swap
      assign din     = swap_bytes(wr_data);
      assign rd_data = swap_bytes(rval);
    end else begin : g_noswap
      assign din     = wr_data;
      assign rd_data = rval;
    end
  endgenerate

  cax_wr_encode #(.XLATE(XLATE)) u_enc (.din(din), .nxt(nxt));
  cax_addr_reg u_reg (.clk(clk), .rst(rst), .wr_en(wr_en), .nxt(nxt), .q(q));
  cax_rd_decode #(.XLATE(XLATE)) u_dec (.q(q), .val(rval));
  cax_irq_swizzle #(.N_DEV(N_DEV), .IRQ_W(IRQ_W), .IRQ_BASE(IRQ_BASE)) u_irq (
    .clk(clk), .rst(rst), .intx(dev_intx), .irq_out(irq_out));

  assign cfg_word = q;

  generate
    if (XLATE) begin : g_xchk
      // R4
      upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cfg_word[30:24] == '0 && cfg_word[1:0] == 2'b00));
      // R6
      onehot_read_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(rval[31:11]) <= 1);
    end else begin : g_pchk
      // R7
      pass_read_chk: assert property (@(posedge clk) disable iff (rst)
        rval[0] && !rval[EN_BIT]);
    end
  endgenerate
endmodule

// File: tb/cfg_addr_xlate_tb.sv
module cfg_addr_xlate_tb;
  localparam int ND = 16;
  localparam int IW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [4*ND-1:0] intx = '0;
  logic [31:0] rd_x, cw_x, rd_b, cw_b, rd_p, cw_p;
  logic [IW-1:0] irq_x, irq_b, irq_p;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_addr_xlate #(.XLATE(1'b1), .BIG_ENDIAN(1'b0), .N_DEV(ND), .IRQ_W(IW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_x),
    .cfg_word(cw_x), .dev_intx(intx), .irq_out(irq_x));
  cfg_addr_xlate #(.XLATE(1'b1), .BIG_ENDIAN(1'b1), .N_DEV(ND), .IRQ_W(IW)) u_be (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_b),
    .cfg_word(cw_b), .dev_intx(intx), .irq_out(irq_b));
  cfg_addr_xlate #(.XLATE(1'b0), .BIG_ENDIAN(1'b0), .N_DEV(ND), .IRQ_W(IW)) u_pt (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_p),
    .cfg_word(cw_p), .dev_intx(intx), .irq_out(irq_p));

  function automatic logic [31:0] sw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] d);
    int dev = 0;
    for (int i = 11; i < 32; i++) begin
      if (d[i]) begin dev = i; break; end
    end
    return 32'h8000_0000 + (d[0] ? 32'h0001_0000 : 32'h0) + (d & 32'h7FC) + 32'(dev * 2048);
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] w);
    int dev = int'(w[15:11]);
    int fn  = int'(w[10:8]);
    return (32'd1 << dev) | 32'(fn * 256) | (w & 32'hFC);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_all(input string req, input logic [31:0] d);
    logic [31:0] wx, wb, wp;
    wx = exp_word(d);
    wb = exp_word(sw(d));
    wp = (d & 32'hFFFF_FFFE) | 32'h8000_0000;
    check({req, " xlate word"}, cw_x, wx);
    check({req, " xlate read R6"}, rd_x, exp_read(wx));
    check({req, " swap word R8"}, cw_b, wb);
    check({req, " swap read R8"}, rd_b, sw(exp_read(wb)));
    check({req, " pass word R7"}, cw_p, wp);
    check({req, " pass read R7"}, rd_p, (wp | 32'h1) & 32'h7FFF_FFFF);
  endtask

  initial begin
    logic [31:0] d, hi, lo;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 xlate word", cw_x, 32'h0);
    check("R1 xlate read", rd_x, 32'h0000_0001);
    check("R1 swap read", rd_b, 32'h0100_0000);
    check("R1 pass read", rd_p, 32'h0000_0001);
    check("R1 irq", 32'(irq_x), 32'h0);

    // R2 R5 R4 literal case
    do_write(32'h0000_0FFF);
    check("R2 R5 literal word", cw_x, 32'h8001_5FFC);
    check("R6 literal read", rd_x, 32'h0000_0FFC);
    check("R8 literal swap word", cw_b, exp_word(32'hFF0F_0000));

    // R8 literal
    do_write(32'h0108_0000);
    check("R8 swap word", cw_b, 32'h8001_5800);
    check("R8 swap read", rd_b, 32'h0008_0000);

    // R7 literal
    do_write(32'h1234_5679);
    check("R7 pass word", cw_p, 32'h9234_5678);
    check("R7 pass read", rd_p, 32'h1234_5679);

    // R3 no select bit
    do_write(32'h0000_0555);
    check("R3 empty select", cw_x, 32'h8001_0554);
    check_all("R3", 32'h0000_0555);

    // R2 R4 R5 sweep
    for (int b = 11; b < 32; b++) begin
      for (int f = 0; f < 4; f++) begin
        lo = (f[1] ? 32'h0000_0556 : 32'h0000_02AA) | 32'(f[0]);
        hi = (f[1] ? 32'hA5A5_A800 : 32'h0) & ~((32'd2 << b) - 32'd1);
        d = (32'd1 << b) | hi | lo;
        do_write(d);
        check_all("R2 R4 R5", d);
      end
    end

    // R9 strobe gating
    do_write(32'h0004_0A01);
    d = cw_x;
    @(negedge clk);
    wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R9 hold", cw_x, d);

    // R10 swizzle sweep
    for (int j = 0; j < ND; j++) begin
      for (int n = 0; n < 4; n++) begin
        @(negedge clk);
        intx = '0;
        intx[4*j + n] = 1'b1;
        @(negedge clk);
        check("R10 R11 swizzle", 32'(irq_x), 32'd1 << (8 + ((n + j) % 4)));
      end
    end
    // R10 OR of sources on one line and on two lines
    @(negedge clk);
    intx = '0; intx[4*1 + 0] = 1'b1; intx[4*0 + 1] = 1'b1;
    @(negedge clk);
    check("R10 same line", 32'(irq_x), 32'h0000_0200);
    intx = '0; intx[0] = 1'b1; intx[2] = 1'b1;
    @(negedge clk);
    check("R10 two lines", 32'(irq_x), 32'h0000_0500);
    intx = '1;
    @(negedge clk);
    check("R11 all sources", 32'(irq_x), 32'h0000_0F00);
    intx = '0;
    @(negedge clk);
    check("R10 release", 32'(irq_x), 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule